// File: doc/BRIEF.md
# Dual-Pair Threshold Window and Crossing Monitor

This block sits behind an analog-to-digital converter and grades every finished conversion result. Each result arrives with a one-cycle valid strobe, a 12-bit value and a 4-bit channel number. The block compares the value against one of two programmable low/high threshold pairs. A per-channel select bit chooses the pair. The block then reports a 2-bit window status and a 2-bit crossing status. The crossing status says whether the value moved across the selected low threshold since the previous result on the same channel.

For each channel the block stores whether that channel has produced a result since reset, and on which side of the low threshold the last result fell. A 2-bit mode per channel decides what raises that channel's sticky event flag: nothing, a result outside the window, or a crossing. Software clears a flag by pulsing its clear bit. A single interrupt line reports that at least one flag is set. The thresholds, pair selects, modes and clear strobes are plain input ports, driven by whatever register block surrounds this one.

Top module: `adc_window_monitor`

## Requirements
- R1: The window status is 0 when low <= value <= high, 1 when value < low, and 2 when value > high. The bounds are inclusive, and the code 3 never appears.
- R2: Bit c of `pairSel` chooses the threshold pair for channel c. A 0 selects `thrLo0`/`thrHi0` and a 1 selects `thrLo1`/`thrHi1`.
- R3: The crossing status compares only against the low threshold of the selected pair. The codes are 0 for no crossing, 2 when the previous result was not below and the current one is below, and 3 when the previous result was below and the current one is not below. A value equal to the low threshold counts as not below.
- R4: The first result on a channel after reset reports crossing status 0. Side history is kept separately per channel, so a result on one channel never affects the crossing status of another.
- R5: `statValid` is high for exactly one cycle, in the cycle after a result with channel 0..11 is sampled. `winStat` and `crossStat` update at the same time and hold their values until the next accepted result.
- R6: A result with channel number 12..15 is ignored. It produces no `statValid` pulse, it leaves `winStat`, `crossStat` and `eventFlags` unchanged, and it records no side history.
- R7: The mode for channel c is `intMode[2c+1:2c]`. Mode 0 raises no event, mode 1 raises an event when the window status is non-zero, mode 2 raises an event when the crossing status is non-zero, and mode 3 raises no event.
- R8: An event on channel c sets bit c of `eventFlags` in the same cycle that `statValid` rises. The bit stays set until a clock edge at which `flagClr[c]` is 1. If a set and a clear on the same bit meet at one edge, the set wins.
- R9: `thrIrq` is 1 exactly when at least one bit of `eventFlags` is set.
- R10: After reset, `statValid`, `winStat`, `crossStat`, `eventFlags` and `thrIrq` are all 0, and no channel has side history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resValid | input | 1 | Conversion result strobe |
| resData | input | 12 | Conversion result value |
| resChan | input | 4 | Channel number of the result |
| thrLo0 | input | 12 | Low threshold, pair 0 |
| thrHi0 | input | 12 | High threshold, pair 0 |
| thrLo1 | input | 12 | Low threshold, pair 1 |
| thrHi1 | input | 12 | High threshold, pair 1 |
| pairSel | input | 12 | Per-channel threshold pair select |
| intMode | input | 24 | Per-channel 2-bit event mode, channel c at bits 2c+1:2c |
| flagClr | input | 12 | Per-channel event flag clear, active at the clock edge |
| statValid | output | 1 | One-cycle pulse when a new status is presented |
| winStat | output | 2 | Window status of the last accepted result |
| crossStat | output | 2 | Crossing status of the last accepted result |
| eventFlags | output | 12 | Sticky per-channel event flags |
| thrIrq | output | 1 | Set while any event flag is set |

## Verification
The hardest cases to reach from the ports are the crossing codes. Each one depends on history that the same channel stored one or more results earlier. The equal-to-low case and the guarantee that one channel's history does not affect another both depend on that history too. The stimulus sends runs of results to a single channel that step back and forth around the low threshold, including a value exactly at it. It then sends a first result to a fresh channel right after another channel was left below its threshold. A set and a clear aimed at the same flag are driven into one clock edge. Out-of-range channel numbers are sent while flags are set and statuses are held, so that any side effect would be visible.

// File: rtl/awm_pkg.sv
package awm_pkg;
  localparam int DATA_W = 12;
  localparam int NUM_CH = 12;
  localparam int CH_W   = 4;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    WIN_INSIDE = 2'd0,
    WIN_BELOW  = 2'd1,
    WIN_ABOVE  = 2'd2
  } winCode_e;

  typedef enum logic [1:0] {
    CROSS_NONE = 2'd0,
    CROSS_DOWN = 2'd2,
    CROSS_UP   = 2'd3
  } crossCode_e;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_OUTSIDE = 2'd1,
    MODE_CROSS   = 2'd2,
    MODE_SPARE   = 2'd3
  } evMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [NUM_CH-1:0] chanHot;
  } awmStrobe_t;
endpackage

// File: rtl/awm_datapath.sv
module awm_datapath
  import awm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  awmStrobe_t        strobe,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] thrLo0,
  input  logic [DATA_W-1:0] thrHi0,
  input  logic [DATA_W-1:0] thrLo1,
  input  logic [DATA_W-1:0] thrHi1,
  input  logic [NUM_CH-1:0] pairSel,
  output logic [1:0]        winNext,
  output logic [1:0]        crossNext,
  output logic              statValid,
  output logic [1:0]        winStat,
  output logic [1:0]        crossStat
);
  logic              usePair1;
  logic [DATA_W-1:0] activeLo;
  logic [DATA_W-1:0] activeHi;
  logic              curBelow;
  logic              curAbove;
  logic [NUM_CH-1:0] seenQ;
  logic [NUM_CH-1:0] notBelowQ;
  logic              prevSeen;
  logic              prevNotBelow;

  // pair selection from the decoded channel
  assign usePair1 = |(pairSel & strobe.chanHot);
  assign activeLo = usePair1 ? thrLo1 : thrLo0;
  assign activeHi = usePair1 ? thrHi1 : thrHi0;

  assign curBelow = (resData < activeLo);
  assign curAbove = (resData > activeHi);

  always_comb begin
    if (curBelow) begin
      winNext = WIN_BELOW;
    end else if (curAbove) begin
      winNext = WIN_ABOVE;
    end else begin
      winNext = WIN_INSIDE;
    end
  end

  // per-channel side history
  for (genvar c = 0; c < NUM_CH; c++) begin : g_side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        seenQ[c]     <= 1'b0;
        notBelowQ[c] <= 1'b0;
      end else if (strobe.load && strobe.chanHot[c]) begin
        seenQ[c]     <= 1'b1;
        notBelowQ[c] <= ~curBelow;
      end
    end
  end

  assign prevSeen     = |(seenQ & strobe.chanHot);
  assign prevNotBelow = |(notBelowQ & strobe.chanHot);

  always_comb begin
    crossNext = CROSS_NONE;
    if (prevSeen) begin
      if (prevNotBelow && curBelow) begin
        crossNext = CROSS_DOWN;
      end else if (!prevNotBelow && !curBelow) begin
        crossNext = CROSS_UP;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statValid <= 1'b0;
      winStat   <= WIN_INSIDE;
      crossStat <= CROSS_NONE;
    end else begin
      statValid <= strobe.load;
      if (strobe.load) begin
        winStat   <= winNext;
        crossStat <= crossNext;
      end
    end
  end
endmodule

// File: rtl/awm_control.sv
module awm_control
  import awm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     resValid,
  input  logic [CH_W-1:0]          resChan,
  input  logic [NUM_CH*MODE_W-1:0] intMode,
  input  logic [NUM_CH-1:0]        flagClr,
  input  logic [1:0]               winNext,
  input  logic [1:0]               crossNext,
  output awmStrobe_t               strobe,
  output logic [NUM_CH-1:0]        eventFlags,
  output logic                     thrIrq
);
  logic [MODE_W-1:0] modeArr [NUM_CH];
  logic [MODE_W-1:0] modeSel;
  logic              chanOk;
  logic              hit;
  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] flagQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    assign modeArr[c] = intMode[c*MODE_W +: MODE_W];
  end

  assign chanOk = (resChan < CH_W'(NUM_CH));

  always_comb begin
    strobe.load    = resValid && chanOk;
    strobe.chanHot = '0;
    modeSel        = MODE_OFF;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobe.load && (resChan == CH_W'(c))) begin
        strobe.chanHot[c] = 1'b1;
        modeSel           = modeArr[c];
      end
    end
  end

  always_comb begin
    case (modeSel)
      MODE_OUTSIDE: hit = (winNext != WIN_INSIDE);
      MODE_CROSS:   hit = (crossNext != CROSS_NONE);
      default:      hit = 1'b0;
    endcase
  end

  assign setVec = hit ? strobe.chanHot : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      flagQ <= (flagQ & ~flagClr) | setVec;
    end
  end

  assign eventFlags = flagQ;
  assign thrIrq     = |flagQ;
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import awm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     resValid,
  input  logic [DATA_W-1:0]        resData,
  input  logic [CH_W-1:0]          resChan,
  input  logic [DATA_W-1:0]        thrLo0,
  input  logic [DATA_W-1:0]        thrHi0,
  input  logic [DATA_W-1:0]        thrLo1,
  input  logic [DATA_W-1:0]        thrHi1,
  input  logic [NUM_CH-1:0]        pairSel,
  input  logic [NUM_CH*MODE_W-1:0] intMode,
  input  logic [NUM_CH-1:0]        flagClr,
  output logic                     statValid,
  output logic [1:0]               winStat,
  output logic [1:0]               crossStat,
  output logic [NUM_CH-1:0]        eventFlags,
  output logic                     thrIrq
);
  awmStrobe_t strobe;
  logic [1:0] winNext;
  logic [1:0] crossNext;

  awm_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .resChan    (resChan),
    .intMode    (intMode),
    .flagClr    (flagClr),
    .winNext    (winNext),
    .crossNext  (crossNext),
    .strobe     (strobe),
    .eventFlags (eventFlags),
    .thrIrq     (thrIrq)
  );

  awm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resData   (resData),
    .thrLo0    (thrLo0),
    .thrHi0    (thrHi0),
    .thrLo1    (thrLo1),
    .thrHi1    (thrHi1),
    .pairSel   (pairSel),
    .winNext   (winNext),
    .crossNext (crossNext),
    .statValid (statValid),
    .winStat   (winStat),
    .crossStat (crossStat)
  );
endmodule

// File: rtl/awm_checker.sv
module awm_checker
  import awm_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     resValid,
  input logic [DATA_W-1:0]        resData,
  input logic [CH_W-1:0]          resChan,
  input logic [DATA_W-1:0]        thrLo0,
  input logic [DATA_W-1:0]        thrHi0,
  input logic [DATA_W-1:0]        thrLo1,
  input logic [DATA_W-1:0]        thrHi1,
  input logic [NUM_CH-1:0]        pairSel,
  input logic [NUM_CH*MODE_W-1:0] intMode,
  input logic [NUM_CH-1:0]        flagClr,
  input logic                     statValid,
  input logic [1:0]               winStat,
  input logic [1:0]               crossStat,
  input logic [NUM_CH-1:0]        eventFlags,
  input logic                     thrIrq
);
  p_win_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> (winStat != 2'd3));

  p_cross_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    crossStat != 2'd1);

  p_cross_down_below_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && crossStat == 2'd2) |-> (winStat == 2'd1));

  p_cross_up_not_below_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && crossStat == 2'd3) |-> (winStat != 2'd1));

  p_accept_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resChan < CH_W'(NUM_CH)) |=> statValid);

  p_bad_chan_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resChan >= CH_W'(NUM_CH)) |=> (!statValid && $stable(winStat) && $stable(crossStat)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(eventFlags) & ~$past(flagClr)) & ~eventFlags) == '0));

  p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((eventFlags & ~$past(eventFlags)) == '0) || $past(resValid)));

  p_one_new_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $onehot0(eventFlags & ~$past(eventFlags)));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(thrIrq) |-> $past(resValid));
endmodule

bind adc_window_monitor awm_checker u_chk (.*);

// File: tb/adc_window_monitor_test.sv
module adc_window_monitor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [11:0] resData = '0;
  logic [3:0]  resChan = '0;
  logic [11:0] thrLo0 = 12'd100;
  logic [11:0] thrHi0 = 12'd200;
  logic [11:0] thrLo1 = 12'd1000;
  logic [11:0] thrHi1 = 12'd2000;
  logic [11:0] pairSel = 12'h002;
  logic [23:0] intMode = (24'd1 << 8) | (24'd2 << 10) | (24'd3 << 14);
  logic [11:0] flagClr = '0;
  logic        statValid;
  logic [1:0]  winStat;
  logic [1:0]  crossStat;
  logic [11:0] eventFlags;
  logic        thrIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_window_monitor uut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resData(resData),
    .resChan(resChan), .thrLo0(thrLo0), .thrHi0(thrHi0), .thrLo1(thrLo1),
    .thrHi1(thrHi1), .pairSel(pairSel), .intMode(intMode), .flagClr(flagClr),
    .statValid(statValid), .winStat(winStat), .crossStat(crossStat),
    .eventFlags(eventFlags), .thrIrq(thrIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one result (and optional clear) for one edge; return at the next negedge
  task automatic sendRes(input int ch, input int val, input logic [11:0] clr);
    @(negedge clk);
    resValid = 1'b1;
    resChan  = 4'(ch);
    resData  = 12'(val);
    flagClr  = clr;
    @(negedge clk);
    resValid = 1'b0;
    flagClr  = '0;
  endtask

  task automatic sendCheck(input string tag, input int ch, input int val,
                           input int expWin, input int expCross);
    sendRes(ch, val, 12'h000);
    check({tag, " statValid"}, int'(statValid), 1);
    check({tag, " winStat"}, int'(winStat), expWin);
    check({tag, " crossStat"}, int'(crossStat), expCross);
  endtask

  task automatic pulseClr(input logic [11:0] clr);
    @(negedge clk);
    flagClr = clr;
    @(negedge clk);
    flagClr = '0;
  endtask

  task automatic testReset();
    check("R10 statValid", int'(statValid), 0);
    check("R10 winStat", int'(winStat), 0);
    check("R10 crossStat", int'(crossStat), 0);
    check("R10 eventFlags", int'(eventFlags), 0);
    check("R10 thrIrq", int'(thrIrq), 0);
  endtask

  task automatic testWindow();
    sendCheck("R1 R4 ch0 150", 0, 150, 0, 0);
    @(negedge clk);
    check("R5 pulse drop", int'(statValid), 0);
    check("R5 winStat held", int'(winStat), 0);
    sendCheck("R1 ch0 99", 0, 99, 1, 2);
    sendCheck("R1 ch0 201", 0, 201, 2, 3);
    @(negedge clk);
    check("R5 crossStat held", int'(crossStat), 3);
    sendCheck("R1 ch0 low edge 100", 0, 100, 0, 0);
    sendCheck("R1 ch0 high edge 200", 0, 200, 0, 0);
  endtask

  task automatic testPair();
    sendCheck("R2 R4 ch1 150", 1, 150, 1, 0);
    sendCheck("R2 ch1 1500", 1, 1500, 0, 3);
    sendCheck("R2 ch1 2500", 1, 2500, 2, 0);
    sendCheck("R2 ch0 150 pair0", 0, 150, 0, 0);
  endtask

  task automatic testCross();
    sendCheck("R4 ch2 first 50", 2, 50, 1, 0);
    sendCheck("R3 ch2 up 150", 2, 150, 0, 3);
    sendCheck("R3 ch2 stay 120", 2, 120, 0, 0);
    sendCheck("R3 ch2 down 80", 2, 80, 1, 2);
    sendCheck("R3 ch2 equal low 100", 2, 100, 0, 3);
    sendCheck("R3 ch2 down 99", 2, 99, 1, 2);
    sendCheck("R3 ch2 stay below 10", 2, 10, 1, 0);
    sendCheck("R4 ch3 fresh 150", 3, 150, 0, 0);
  endtask

  task automatic testModes();
    sendCheck("R7 ch4 inside", 4, 150, 0, 0);
    check("R7 ch4 inside no flag", int'(eventFlags), 0);
    sendCheck("R7 ch4 outside", 4, 250, 2, 0);
    check("R7 R8 ch4 flag", int'(eventFlags), 'h010);
    check("R9 irq set", int'(thrIrq), 1);
    sendCheck("R7 ch5 first outside", 5, 250, 2, 0);
    check("R7 ch5 no cross no flag", int'(eventFlags), 'h010);
    sendCheck("R7 ch5 cross down", 5, 50, 1, 2);
    check("R7 ch5 flag", int'(eventFlags), 'h030);
    sendCheck("R7 ch6 a", 6, 50, 1, 0);
    sendCheck("R7 ch6 b", 6, 250, 2, 3);
    sendCheck("R7 ch7 a", 7, 50, 1, 0);
    sendCheck("R7 ch7 b", 7, 250, 2, 3);
    check("R7 mode0 mode3 no flag", int'(eventFlags), 'h030);
  endtask

  task automatic testBadChan();
    sendRes(12, 50, 12'h000);
    check("R6 ch12 no pulse", int'(statValid), 0);
    check("R6 ch12 winStat held", int'(winStat), 2);
    check("R6 ch12 crossStat held", int'(crossStat), 3);
    check("R6 ch12 flags held", int'(eventFlags), 'h030);
    sendRes(15, 4000, 12'h000);
    check("R6 ch15 no pulse", int'(statValid), 0);
    check("R6 ch15 winStat held", int'(winStat), 2);
    // ch8 has no history: a bad channel must not have recorded any
    sendCheck("R6 ch8 fresh after bad", 8, 150, 0, 0);
  endtask

  task automatic testClear();
    pulseClr(12'h010);
    check("R8 clear ch4", int'(eventFlags), 'h020);
    check("R9 irq still set", int'(thrIrq), 1);
    pulseClr(12'h020);
    check("R8 clear ch5", int'(eventFlags), 0);
    check("R9 irq cleared", int'(thrIrq), 0);
    sendRes(4, 300, 12'h010);
    check("R8 set wins over clear", int'(eventFlags), 'h010);
    check("R9 irq after set", int'(thrIrq), 1);
    pulseClr(12'h010);
    check("R8 final clear", int'(eventFlags), 0);
    check("R9 final irq", int'(thrIrq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWindow();
    testPair();
    testCross();
    testModes();
    testBadChan();
    testClear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule